// File: doc/BRIEF.md
# Memory-Access Pattern Matcher

This block follows a processor's per-instruction reports and verifies them against a compact expected trace. In that trace only the memory accesses are written out. Every entry of the trace names one access: whether it is a load or a store, and which register it targets. The entry also holds the number of non-memory instructions that must come before that access. An external pattern store holds the entries. The block presents an index on `pat_idx` and reads the entry back on `pat_word` in the same cycle.

While the wildcard run of the current entry is not yet used up, the block accepts any report that is not a memory access. Once the run is complete, the next valid report must be the expected access kind on the expected register. The block compares the register and never the memory address, so data that is placed at run time does not cause false alarms. If the access matches, the block pulses `hit` and moves on to the next entry. If it does not match, the block pulses `miss` and freezes until reset. When the entry that closes the trace has matched, `done` is raised and held.

Top module: `lsm_matcher`

## Requirements
- R1: After reset, `pat_idx` is 0 and `hit`, `miss`, `stopped` and `done` are all low.
- R2: While fewer wildcards have been consumed than the current entry's count (entry bits [7:0]), each valid report with both `rpt_load` and `rpt_store` low is accepted silently and consumes one wildcard.
- R3: Once the count is consumed, a valid report of the expected kind and register produces a one-cycle `hit` on the next clock edge. The kind is entry bit 8 (0 = load, 1 = store), and the register is entry bits 12:9. On that same edge `pat_idx` advances by one and the wildcard tally restarts at zero.
- R4: A valid load or store that arrives while wildcards remain produces a one-cycle `miss` on the next edge.
- R5: When the access is due, a valid report produces `miss` in any of these cases: it names the wrong kind, it names the wrong register, it is not a memory access, or it asserts both `rpt_load` and `rpt_store`.
- R6: After a `miss`, `stopped` stays high until reset, `pat_idx` holds, and no further `hit` or `miss` occurs.
- R7: An entry whose count is zero requires its access as the very first valid report for that entry.
- R8: When the entry with its last flag set (entry bit 13) matches, `done` rises together with `hit` and stays high. Later reports cause no pulse and leave `pat_idx` unchanged.
- R9: Cycles with `rpt_valid` low change nothing, whatever the other report inputs carry.
- R10: The entry at the highest index (DEPTH-1) ends the trace when matched, even if its last flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rpt_valid | input | 1 | One instruction is reported this cycle |
| rpt_load | input | 1 | Reported instruction is a load |
| rpt_store | input | 1 | Reported instruction is a store |
| rpt_reg | input | REG_W (4) | Target register of the reported access |
| pat_idx | output | IDX_W (4) | Index of the current pattern entry |
| pat_word | input | CNT_W+REG_W+2 (14) | Pattern entry at `pat_idx`: {last, reg, kind, count} |
| hit | output | 1 | One-cycle pulse: expected access matched |
| miss | output | 1 | One-cycle pulse: report deviated from the pattern |
| stopped | output | 1 | Matcher halted after a mismatch |
| done | output | 1 | Final entry matched |

## Verification
The checker runs every cycle. It checks that `hit` and `miss` never coincide and only follow a valid report. It checks that `hit` only follows a memory access, that `stopped` and `done` are sticky and exclusive, that a halted or finished matcher stays silent, and that each non-final hit advances the index by one. Several behaviours depend on pattern contents and can only be shown by the bench's scenarios: whether a given report is judged correct by kind and register, how the wildcard count is honoured (including a count of zero), that idle cycles are ignored, and that the trace ends at the flagged entry or at the top index.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_DONE = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_rst_sync.sv
module lsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lsm_entry_decode.sv
module lsm_entry_decode #(
  parameter int CNT_W = 8,
  parameter int REG_W = 4,
  localparam int ENTRY_W = CNT_W + REG_W + 2
) (
  input  logic [ENTRY_W-1:0] word,
  output logic [CNT_W-1:0]   count,
  output logic               want_store,
  output logic [REG_W-1:0]   want_reg,
  output logic               last
);
  localparam int KIND_POS = CNT_W;
  localparam int REG_LO   = CNT_W + 1;
  localparam int LAST_POS = CNT_W + REG_W + 1;

  assign count      = word[CNT_W-1:0];
  assign want_store = word[KIND_POS];
  assign want_reg   = word[REG_LO +: REG_W];
  assign last       = word[LAST_POS];
endmodule

// File: rtl/lsm_wild_counter.sv
module lsm_wild_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             due
);
  logic [CNT_W-1:0] seen_q, seen_d;
  logic             seen_en;

  always_comb begin
    seen_en = inc | clr;
    seen_d  = seen_q;
    if (clr)      seen_d = '0;
    else if (inc) seen_d = seen_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end

  assign due = (seen_q == limit);
endmodule

// File: rtl/lsm_seq_ctrl.sv
module lsm_seq_ctrl
  import lsm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int REG_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rpt_valid,
  input  logic             rpt_load,
  input  logic             rpt_store,
  input  logic [REG_W-1:0] rpt_reg,
  input  logic             due,
  input  logic             want_store,
  input  logic [REG_W-1:0] want_reg,
  input  logic             last,
  output logic             cnt_inc,
  output logic             cnt_clr,
  output logic [IDX_W-1:0] idx,
  output logic             hit,
  output logic             miss,
  output logic             stopped,
  output logic             done
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

  lsm_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hit_q, hit_d, miss_q, miss_d;
  logic             is_mem, kind_ok, final_entry, idx_en, st_en;

  always_comb begin
    is_mem      = rpt_load | rpt_store;
    kind_ok     = want_store ? (rpt_store & ~rpt_load) : (rpt_load & ~rpt_store);
    final_entry = last | (idx_q == TOP_IDX);
    st_d    = st_q;
    idx_d   = idx_q;
    hit_d   = 1'b0;
    miss_d  = 1'b0;
    cnt_inc = 1'b0;
    cnt_clr = 1'b0;
    if (st_q == ST_RUN && rpt_valid) begin
      if (!due) begin
        if (is_mem) begin
          miss_d = 1'b1;
          st_d   = ST_STOP;
        end else begin
          cnt_inc = 1'b1;
        end
      end else if (kind_ok && rpt_reg == want_reg) begin
        hit_d   = 1'b1;
        cnt_clr = 1'b1;
        if (final_entry) st_d  = ST_DONE;
        else             idx_d = idx_q + 1'b1;
      end else begin
        miss_d = 1'b1;
        st_d   = ST_STOP;
      end
    end
    idx_en = (idx_d != idx_q);
    st_en  = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      idx_q  <= '0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (idx_en) idx_q <= idx_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign idx     = idx_q;
  assign hit     = hit_q;
  assign miss    = miss_q;
  assign stopped = (st_q == ST_STOP);
  assign done    = (st_q == ST_DONE);
endmodule

// File: rtl/lsm_matcher.sv
module lsm_matcher #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  parameter int REG_W = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ENTRY_W = CNT_W + REG_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rpt_valid,
  input  logic               rpt_load,
  input  logic               rpt_store,
  input  logic [REG_W-1:0]   rpt_reg,
  output logic [IDX_W-1:0]   pat_idx,
  input  logic [ENTRY_W-1:0] pat_word,
  output logic               hit,
  output logic               miss,
  output logic               stopped,
  output logic               done
);
  logic             rst_n_s;
  logic [CNT_W-1:0] count;
  logic             want_store, last, due, cnt_inc, cnt_clr;
  logic [REG_W-1:0] want_reg;

  lsm_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  lsm_entry_decode #(.CNT_W(CNT_W), .REG_W(REG_W)) dec_i (
    .word(pat_word), .count(count), .want_store(want_store),
    .want_reg(want_reg), .last(last)
  );

  lsm_wild_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n_s), .inc(cnt_inc), .clr(cnt_clr),
    .limit(count), .due(due)
  );

  lsm_seq_ctrl #(.DEPTH(DEPTH), .REG_W(REG_W)) seq_i (
    .clk(clk), .rst_n(rst_n_s),
    .rpt_valid(rpt_valid), .rpt_load(rpt_load), .rpt_store(rpt_store),
    .rpt_reg(rpt_reg), .due(due), .want_store(want_store),
    .want_reg(want_reg), .last(last), .cnt_inc(cnt_inc), .cnt_clr(cnt_clr),
    .idx(pat_idx), .hit(hit), .miss(miss), .stopped(stopped), .done(done)
  );
endmodule

// File: rtl/lsm_matcher_chk.sv
module lsm_matcher_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rpt_valid,
  input logic             rpt_load,
  input logic             rpt_store,
  input logic [IDX_W-1:0] pat_idx,
  input logic             hit,
  input logic             miss,
  input logic             stopped,
  input logic             done
);
  // R3 / R5: a report is judged one way only
  a_r3_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  // R9: pulses only follow a valid report
  a_r9_pulse_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> $past(rpt_valid));

  // R3: a hit is always the answer to a memory access
  a_r3_hit_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(rpt_load || rpt_store));

  // R3: a hit that does not end the trace steps the index by one
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !done) |-> (pat_idx == IDX_W'($past(pat_idx) + 1'b1)));

  // R6: mismatch halts at once and the halt persists
  a_r6_miss_halts: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> stopped);
  a_r6_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped);

  // R6 / R8: a halted or finished matcher stays silent and holds its index
  a_r6_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped || done) |=> (!hit && !miss && $stable(pat_idx)));

  // R8: completion is sticky, arrives with a hit, never with a halt
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r8_done_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> hit);
  a_r8_done_not_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && stopped));
endmodule

bind lsm_matcher lsm_matcher_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_load(rpt_load),
  .rpt_store(rpt_store), .pat_idx(pat_idx), .hit(hit), .miss(miss),
  .stopped(stopped), .done(done)
);

// File: tb/lsm_matcher_tb.sv
module lsm_matcher_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = 8;
  localparam int REG_W = 4;
  localparam int IDX_W = 4;
  localparam int ENTRY_W = CNT_W + REG_W + 2;

  logic clk, rst_n;
  logic rpt_valid, rpt_load, rpt_store;
  logic [REG_W-1:0] rpt_reg;
  logic [IDX_W-1:0] pat_idx;
  logic [ENTRY_W-1:0] pat_word;
  logic hit, miss, stopped, done;
  logic [ENTRY_W-1:0] pmem [DEPTH];

  int n_checks = 0;
  int n_errors = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign pat_word = pmem[pat_idx];

  lsm_matcher #(.DEPTH(DEPTH), .CNT_W(CNT_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_load(rpt_load),
    .rpt_store(rpt_store), .rpt_reg(rpt_reg), .pat_idx(pat_idx),
    .pat_word(pat_word), .hit(hit), .miss(miss), .stopped(stopped), .done(done)
  );

  function automatic logic [ENTRY_W-1:0] ent(input int cnt, input bit st,
                                             input int rg, input bit lst);
    return {lst, REG_W'(rg), st, CNT_W'(cnt)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // status packed as {hit, miss, stopped, done}
  function automatic int stat();
    return {hit, miss, stopped, done};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; rpt_valid = 1'b0; rpt_load = 1'b0; rpt_store = 1'b0; rpt_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_pat();
    for (int i = 0; i < DEPTH; i++) pmem[i] = ent(0, 1'b0, 0, 1'b0);
  endtask

  // one report, outputs sampled at the following falling edge
  task automatic send(input bit ld, input bit st, input int rg);
    @(negedge clk);
    rpt_valid = 1'b1; rpt_load = ld; rpt_store = st; rpt_reg = REG_W'(rg);
    @(negedge clk);
    rpt_valid = 1'b0; rpt_load = 1'b0; rpt_store = 1'b0;
  endtask

  task automatic t_reset_state();
    clear_pat();
    do_reset();
    check("R1 idx", int'(pat_idx), 0);
    check("R1 flags", stat(), 0);
  endtask

  task automatic t_main_trace();
    clear_pat();
    pmem[0] = ent(2, 1'b0, 3, 1'b0);
    pmem[1] = ent(0, 1'b1, 5, 1'b0);
    pmem[2] = ent(1, 1'b0, 7, 1'b1);
    do_reset();
    send(0, 0, 9);  check("R2 wildcard 1", stat(), 0);
    send(0, 0, 3);  check("R2 wildcard 2", stat(), 0);
    check("R2 idx held", int'(pat_idx), 0);
    send(1, 0, 3);  check("R3 load hit", stat(), 4'b1000);
    check("R3 idx step", int'(pat_idx), 1);
    send(0, 1, 5);  check("R7 zero-count store hit", stat(), 4'b1000);
    check("R7 idx step", int'(pat_idx), 2);
    send(0, 0, 0);  check("R2 wildcard 3", stat(), 0);
    send(1, 0, 7);  check("R8 final hit with done", stat(), 4'b1001);
    send(1, 1, 2);  check("R8 ignored after done", stat(), 4'b0001);
    send(0, 1, 5);  check("R8 idx frozen", int'(pat_idx), 2);
  endtask

  task automatic t_early_access();
    clear_pat();
    pmem[0] = ent(3, 1'b0, 1, 1'b0);
    do_reset();
    send(0, 0, 0);  check("R2 wildcard", stat(), 0);
    send(1, 0, 1);  check("R4 early load miss", stat(), 4'b0110);
    send(0, 0, 0);  check("R6 silent when stopped", stat(), 4'b0010);
    send(0, 0, 0);
    send(1, 0, 1);  check("R6 no hit when stopped", stat(), 4'b0010);
    check("R6 idx held", int'(pat_idx), 0);
  endtask

  task automatic t_due_mismatch(input string tag, input bit ld, input bit st, input int rg);
    clear_pat();
    pmem[0] = ent(0, 1'b0, 2, 1'b0);
    do_reset();
    send(ld, st, rg);
    check(tag, stat(), 4'b0110);
  endtask

  task automatic t_idle_ignored();
    clear_pat();
    pmem[0] = ent(1, 1'b1, 6, 1'b0);
    do_reset();
    @(negedge clk);
    rpt_valid = 1'b0; rpt_load = 1'b1; rpt_store = 1'b1; rpt_reg = 4'd6;
    repeat (5) @(negedge clk);
    check("R9 idle no pulse", stat(), 0);
    check("R9 idle idx", int'(pat_idx), 0);
    rpt_load = 1'b0; rpt_store = 1'b0;
    send(0, 0, 0);  check("R9 wildcard still owed", stat(), 0);
    send(0, 1, 6);  check("R9 store hit after idle", stat(), 4'b1000);
  endtask

  task automatic t_top_index();
    clear_pat();
    for (int i = 0; i < DEPTH; i++) pmem[i] = ent(0, 1'b0, i % 16, 1'b0);
    do_reset();
    for (int i = 0; i < DEPTH - 1; i++) send(1, 0, i % 16);
    check("R10 not done before top", stat(), 4'b1000);
    check("R10 idx at top", int'(pat_idx), DEPTH - 1);
    send(1, 0, (DEPTH - 1) % 16);
    check("R10 done at top index", stat(), 4'b1001);
  endtask

  initial begin
    rst_n = 1'b0; rpt_valid = 1'b0; rpt_load = 1'b0; rpt_store = 1'b0; rpt_reg = '0;
    t_reset_state();
    t_main_trace();
    t_early_access();
    t_due_mismatch("R5 wrong register", 1'b1, 1'b0, 3);
    t_due_mismatch("R5 wrong kind", 1'b0, 1'b1, 2);
    t_due_mismatch("R5 non-memory when due", 1'b0, 1'b0, 2);
    t_due_mismatch("R5 both flags", 1'b1, 1'b1, 2);
    t_idle_ignored();
    t_top_index();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule